// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sequences the taking of interrupts and traps for a small three-stage RISC core. In its idle state it looks at three external interrupt lines and six program trap lines and picks one by fixed priority. It then stalls the pipeline until the core reports that the pipeline is drained. Next it pushes the interrupted PC and then the status word onto a downward-growing interrupt stack. Finally it fetches the handler address from a dispatch table at `intBase + code` and hands the core a new PC, together with a status word that has the interrupt-enable bit cleared.

A return request runs the mirror sequence. After draining, the sequencer pops the status word and then the PC, and loads both back into the core in the same cycle. A register-write or explicit-exception instruction can also ask for plain serialization. This holds the stall until the pipeline is empty and touches no memory. The memory port has one-cycle read latency: read data is expected on `memRdata` in the cycle after the request.

Top module: `excSequencer`

## Requirements
- R1: After reset `stall`, `memReq`, `pcLoad`, `psrLoad` and `excTaken` are low and `ispOut` equals the `ISP_RESET` parameter.
- R2: In the idle state a request is accepted in the same cycle, with `excTaken` high and `excCode` giving the winner. The codes are non-maskable = 1 and emulator = 2. The trap lines `trapReq[0..5]` (supervisor call, divide-by-zero, flag, breakpoint, trace, undefined) take codes 3 to 8. The maskable interrupt takes code 9. Priority runs non-maskable, then emulator, then traps (lower index first), then maskable.
- R3: A maskable request while `curPsr[IE_BIT]` (bit 9 by default) is 0 is ignored: no `excTaken`, no stall, no memory access, and the stack pointer is unchanged.
- R4: After acceptance `stall` is high and the memory port is idle until `pipeEmpty` is seen high. `stall` stays high through the cycle that loads the handler and is low the cycle after.
- R5: The first memory access after draining writes the captured PC (zero-extended) at `isp-1`. The next writes the captured status word at `isp-2`. The stack pointer then equals `isp-2`, so it points at the most recently stored word.
- R6: The next access reads address `intBase + code`. One cycle later `pcLoad` is high and `pcNext` is the word read, truncated to the PC width.
- R7: In the `pcLoad` cycle of an entry, `psrLoad` is high and `psrNext` is the captured status word with only the interrupt-enable bit cleared.
- R8: A `retxReq` in idle with no exception pending stalls until drained. It then reads the status word at `isp` and the PC at `isp+1`, and then raises `pcLoad` and `psrLoad` together with those values. The stack pointer ends at `isp+2`.
- R9: A `ctrlSerialize` in idle with no exception or return pending holds `stall` high until `pipeEmpty` is seen. It makes no memory access and no load, and `stall` drops the cycle after `pipeEmpty` is sampled.
- R10: An accepted exception takes precedence over `retxReq` and `ctrlSerialize` raised in the same cycle. The entry sequence runs and those requests are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqMask | input | 1 | Maskable interrupt request |
| irqNmi | input | 1 | Non-maskable interrupt request |
| irqEmu | input | 1 | In-system emulator interrupt request |
| trapReq | input | 6 | Program trap requests, one per trap kind |
| retxReq | input | 1 | Return-from-exception request |
| ctrlSerialize | input | 1 | Serialize request from a register write or exception instruction |
| pipeEmpty | input | 1 | Pipeline drained indication |
| curPc | input | AW | PC to save on entry |
| curPsr | input | DW | Status word to save on entry |
| intBase | input | AW | Dispatch table base |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data, valid the cycle after a read |
| pcLoad | output | 1 | Redirect fetch to `pcNext` |
| pcNext | output | AW | New PC |
| psrLoad | output | 1 | Load `psrNext` into the status register |
| psrNext | output | DW | New status word |
| stall | output | 1 | Serialize / stall the pipeline |
| excTaken | output | 1 | Exception accepted this cycle |
| excCode | output | 4 | Code of the accepted exception |
| ispOut | output | AW | Current interrupt stack pointer |

## Verification
The bench builds the block with an 8-bit PC and address width, a 16-bit status word, interrupt-enable at bit 9, a stack reset value of 0xE0, and a dispatch table at 0x10 in a 256-word model memory. At this size every one of the 512 combinations of the nine request lines can be swept under both interrupt-enable states. Each accepted case runs a full entry and return, with drain delays of zero to two cycles and with simultaneous return and serialize requests. A nested entry, serialize and double return then shows that the stack unwinds in order.

// File: rtl/excPkg.sv
package excPkg;

  localparam int NUM_TRAPS = 6;
  localparam int CODE_W    = 4;

  typedef logic [CODE_W-1:0] excCode_t;

  localparam excCode_t CODE_NONE  = 4'd0;
  localparam excCode_t CODE_NMI   = 4'd1;
  localparam excCode_t CODE_EMU   = 4'd2;
  localparam excCode_t CODE_TRAP0 = 4'd3;
  localparam excCode_t CODE_MASK  = 4'd9;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EDRAIN,
    ST_PUSHPC,
    ST_PUSHPSR,
    ST_VECRD,
    ST_VECLD,
    ST_RDRAIN,
    ST_POP1,
    ST_POP2,
    ST_POP3,
    ST_SDRAIN
  } seqState_t;

  typedef enum logic [1:0] {
    ADDR_PUSH,
    ADDR_POP,
    ADDR_VEC
  } addrSel_t;

  typedef struct packed {
    logic     capture;
    logic     ispDec;
    logic     ispInc;
    addrSel_t addrSel;
    logic     wrPsr;
    logic     grabPsr;
    logic     loadHandler;
    logic     loadRestore;
    logic     memReq;
    logic     memWe;
  } seqStrobe_t;

endpackage

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IE_BIT = 9,
  parameter int unsigned ISP_RESET = 32'h0000_FF00
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    st,
  input  excCode_t      code,
  input  logic [AW-1:0] curPc,
  input  logic [DW-1:0] curPsr,
  input  logic [AW-1:0] intBase,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] pcNext,
  output logic [DW-1:0] psrNext,
  output logic [AW-1:0] ispOut
);

  localparam logic [AW-1:0] ISP_INIT = AW'(ISP_RESET);
  localparam logic [DW-1:0] IE_MASK  = DW'(1) << IE_BIT;

  logic [AW-1:0] ispQ;
  logic [AW-1:0] savedPc;
  logic [DW-1:0] savedPsr;
  logic [DW-1:0] poppedPsr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ispQ      <= ISP_INIT;
      savedPc   <= '0;
      savedPsr  <= '0;
      poppedPsr <= '0;
    end else begin
      if (st.capture) begin
        savedPc  <= curPc;
        savedPsr <= curPsr;
      end
      if (st.ispDec)
        ispQ <= ispQ - AW'(1);
      else if (st.ispInc)
        ispQ <= ispQ + AW'(1);
      if (st.grabPsr)
        poppedPsr <= memRdata;
    end
  end

  always_comb begin
    unique case (st.addrSel)
      ADDR_PUSH: memAddr = ispQ - AW'(1);
      ADDR_POP:  memAddr = ispQ;
      ADDR_VEC:  memAddr = intBase + AW'(code);
      default:   memAddr = ispQ;
    endcase
  end

  assign memWdata = st.wrPsr ? savedPsr : DW'(savedPc);
  assign pcNext   = AW'(memRdata);
  assign psrNext  = st.loadHandler ? (savedPsr & ~IE_MASK) : poppedPsr;
  assign ispOut   = ispQ;

  assert_isp_dec_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.ispDec |=> ispQ == $past(ispQ) - AW'(1));

  assert_isp_inc_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.ispInc |=> ispQ == $past(ispQ) + AW'(1));

  assert_push_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.memReq && st.memWe && st.wrPsr) |-> $past(st.memReq && st.memWe && !st.wrPsr));

  assert_ie_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.loadHandler |-> (psrNext & IE_MASK) == '0);

  assert_pop_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.loadRestore |-> $past(st.grabPsr));

endmodule

// File: rtl/excControl.sv
module excControl
  import excPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 irqMask,
  input  logic                 irqNmi,
  input  logic                 irqEmu,
  input  logic [NUM_TRAPS-1:0] trapReq,
  input  logic                 retxReq,
  input  logic                 ctrlSerialize,
  input  logic                 pipeEmpty,
  input  logic                 ieNow,
  output seqStrobe_t           st,
  output excCode_t             code,
  output logic                 excTaken,
  output excCode_t             excCode,
  output logic                 stall,
  output logic                 pcLoad,
  output logic                 psrLoad
);

  seqState_t stateQ, stateD;
  excCode_t  codeQ;
  excCode_t  pick;

  // Lowest priority assigned first, so later lines override.
  always_comb begin
    pick = CODE_NONE;
    if (irqMask && ieNow) pick = CODE_MASK;
    for (int i = NUM_TRAPS - 1; i >= 0; i--) begin
      if (trapReq[i]) pick = CODE_TRAP0 + excCode_t'(i);
    end
    if (irqEmu) pick = CODE_EMU;
    if (irqNmi) pick = CODE_NMI;
  end

  assign excTaken = (stateQ == ST_IDLE) && (pick != CODE_NONE);
  assign excCode  = excTaken ? pick : CODE_NONE;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (pick != CODE_NONE) stateD = ST_EDRAIN;
        else if (retxReq)      stateD = ST_RDRAIN;
        else if (ctrlSerialize) stateD = ST_SDRAIN;
      end
      ST_EDRAIN:  if (pipeEmpty) stateD = ST_PUSHPC;
      ST_PUSHPC:  stateD = ST_PUSHPSR;
      ST_PUSHPSR: stateD = ST_VECRD;
      ST_VECRD:   stateD = ST_VECLD;
      ST_VECLD:   stateD = ST_IDLE;
      ST_RDRAIN:  if (pipeEmpty) stateD = ST_POP1;
      ST_POP1:    stateD = ST_POP2;
      ST_POP2:    stateD = ST_POP3;
      ST_POP3:    stateD = ST_IDLE;
      ST_SDRAIN:  if (pipeEmpty) stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      codeQ  <= CODE_NONE;
    end else begin
      stateQ <= stateD;
      if (excTaken) codeQ <= pick;
    end
  end

  always_comb begin
    st = '0;
    st.addrSel = ADDR_POP;
    unique case (stateQ)
      ST_IDLE: st.capture = excTaken;
      ST_PUSHPC: begin
        st.memReq  = 1'b1;
        st.memWe   = 1'b1;
        st.ispDec  = 1'b1;
        st.addrSel = ADDR_PUSH;
      end
      ST_PUSHPSR: begin
        st.memReq  = 1'b1;
        st.memWe   = 1'b1;
        st.ispDec  = 1'b1;
        st.addrSel = ADDR_PUSH;
        st.wrPsr   = 1'b1;
      end
      ST_VECRD: begin
        st.memReq  = 1'b1;
        st.addrSel = ADDR_VEC;
      end
      ST_VECLD: st.loadHandler = 1'b1;
      ST_POP1: begin
        st.memReq = 1'b1;
        st.ispInc = 1'b1;
      end
      ST_POP2: begin
        st.memReq  = 1'b1;
        st.ispInc  = 1'b1;
        st.grabPsr = 1'b1;
      end
      ST_POP3: st.loadRestore = 1'b1;
      default: ;
    endcase
  end

  assign code    = codeQ;
  assign stall   = stateQ != ST_IDLE;
  assign pcLoad  = st.loadHandler || st.loadRestore;
  assign psrLoad = st.loadHandler || st.loadRestore;

  assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> !stall);

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCode == CODE_MASK) |-> (ieNow && !irqNmi && !irqEmu && trapReq == '0));

  assert_drain_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> !st.memReq);

  assert_serial_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SDRAIN && !pipeEmpty) |=> (stall && !st.memReq));

endmodule

// File: rtl/excSequencer.sv
module excSequencer
  import excPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IE_BIT = 9,
  parameter int unsigned ISP_RESET = 32'h0000_FF00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 irqMask,
  input  logic                 irqNmi,
  input  logic                 irqEmu,
  input  logic [NUM_TRAPS-1:0] trapReq,
  input  logic                 retxReq,
  input  logic                 ctrlSerialize,
  input  logic                 pipeEmpty,
  input  logic [AW-1:0]        curPc,
  input  logic [DW-1:0]        curPsr,
  input  logic [AW-1:0]        intBase,
  output logic                 memReq,
  output logic                 memWe,
  output logic [AW-1:0]        memAddr,
  output logic [DW-1:0]        memWdata,
  input  logic [DW-1:0]        memRdata,
  output logic                 pcLoad,
  output logic [AW-1:0]        pcNext,
  output logic                 psrLoad,
  output logic [DW-1:0]        psrNext,
  output logic                 stall,
  output logic                 excTaken,
  output logic [CODE_W-1:0]    excCode,
  output logic [AW-1:0]        ispOut
);

  seqStrobe_t st;
  excCode_t   code;

  excControl i_control (
    .clk          (clk),
    .rstN         (rstN),
    .irqMask      (irqMask),
    .irqNmi       (irqNmi),
    .irqEmu       (irqEmu),
    .trapReq      (trapReq),
    .retxReq      (retxReq),
    .ctrlSerialize(ctrlSerialize),
    .pipeEmpty    (pipeEmpty),
    .ieNow        (curPsr[IE_BIT]),
    .st           (st),
    .code         (code),
    .excTaken     (excTaken),
    .excCode      (excCode),
    .stall        (stall),
    .pcLoad       (pcLoad),
    .psrLoad      (psrLoad)
  );

  excDatapath #(
    .AW       (AW),
    .DW       (DW),
    .IE_BIT   (IE_BIT),
    .ISP_RESET(ISP_RESET)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .code    (code),
    .curPc   (curPc),
    .curPsr  (curPsr),
    .intBase (intBase),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .pcNext  (pcNext),
    .psrNext (psrNext),
    .ispOut  (ispOut)
  );

  assign memReq = st.memReq;
  assign memWe  = st.memWe;

endmodule

// File: tb/test_excSequencer.sv
module test_excSequencer;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IE_BIT = 9;
  localparam int unsigned ISPR = 32'hE0;
  localparam logic [AW-1:0] TBASE = 8'h10;

  logic clk = 0;
  logic rstN = 0;
  logic irqMask = 0, irqNmi = 0, irqEmu = 0;
  logic [5:0] trapReq = '0;
  logic retxReq = 0, ctrlSerialize = 0, pipeEmpty = 1;
  logic [AW-1:0] curPc = '0;
  logic [DW-1:0] curPsr = '0;
  logic [AW-1:0] intBase = TBASE;
  logic memReq, memWe, pcLoad, psrLoad, stall, excTaken;
  logic [AW-1:0] memAddr, pcNext, ispOut;
  logic [DW-1:0] memWdata, psrNext;
  logic [DW-1:0] memRdata = '0;
  logic [3:0] excCode;

  logic [DW-1:0] mem [256];

  int checks = 0;
  int fails = 0;

  logic [AW-1:0] ispModel;
  logic [AW-1:0] stkPc [8];
  logic [DW-1:0] stkPsr [8];
  int depth = 0;

  always #2.5 clk = ~clk;

  excSequencer #(.AW(AW), .DW(DW), .IE_BIT(IE_BIT), .ISP_RESET(ISPR)) i_excSequencer (
    .clk(clk), .rstN(rstN), .irqMask(irqMask), .irqNmi(irqNmi), .irqEmu(irqEmu),
    .trapReq(trapReq), .retxReq(retxReq), .ctrlSerialize(ctrlSerialize),
    .pipeEmpty(pipeEmpty), .curPc(curPc), .curPsr(curPsr), .intBase(intBase),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .pcLoad(pcLoad), .pcNext(pcNext), .psrLoad(psrLoad),
    .psrNext(psrNext), .stall(stall), .excTaken(excTaken), .excCode(excCode),
    .ispOut(ispOut)
  );

  always @(posedge clk) begin
    if (memReq && memWe) mem[memAddr] <= memWdata;
    else if (memReq)     memRdata <= mem[memAddr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expCode(input logic [8:0] pat, input bit ie);
    if (pat[0]) return 1;
    if (pat[1]) return 2;
    for (int i = 0; i < 6; i++) if (pat[2+i]) return 3 + i;
    if (pat[8] && ie) return 9;
    return 0;
  endfunction

  function automatic logic [AW-1:0] handlerOf(input int c);
    return AW'(8'h40 + c * 5);
  endfunction

  task automatic clearIn();
    irqNmi = 0; irqEmu = 0; trapReq = '0; irqMask = 0;
    retxReq = 0; ctrlSerialize = 0;
  endtask

  task automatic entryRun(input logic [8:0] pat, input bit ie, input logic [AW-1:0] pc,
                          input int dp, input bit others);
    int ec;
    logic [DW-1:0] psr;
    bit oth;
    psr = 16'hA000 | {7'd0, pat};
    psr[IE_BIT] = ie;
    ec = expCode(pat, ie);
    oth = others && (ec != 0);
    @(negedge clk);
    irqNmi = pat[0]; irqEmu = pat[1]; trapReq = pat[7:2]; irqMask = pat[8];
    curPc = pc; curPsr = psr; pipeEmpty = 1;
    retxReq = oth; ctrlSerialize = oth;
    #1;
    chk(excTaken == (ec != 0), "R2 excTaken", excTaken, ec != 0);
    if (ec != 0) chk(excCode == 4'(ec), "R2 excCode", excCode, ec);
    if (ec == 0) begin
      @(negedge clk);
      clearIn();
      chk(!stall && !memReq && !pcLoad, "R3 ignored request", {stall, memReq, pcLoad}, 0);
      chk(ispOut == ispModel, "R3 isp unchanged", ispOut, ispModel);
      return;
    end
    for (int i = 1; i <= dp + 5; i++) begin
      @(negedge clk);
      clearIn();
      pipeEmpty = (i > dp);
      if (i <= dp + 1)
        chk(stall && !memReq, "R4 drain quiet", {stall, memReq}, 2'b10);
      else if (i == dp + 2) begin
        chk(memReq && memWe && memAddr == ispModel - 1 && memWdata == DW'(pc),
            "R5 push pc", {memAddr, memWdata}, {ispModel - 8'd1, DW'(pc)});
        if (oth) chk(memWe, "R10 exception wins", memWe, 1);
      end else if (i == dp + 3)
        chk(memReq && memWe && memAddr == ispModel - 2 && memWdata == psr,
            "R5 push psr", {memAddr, memWdata}, {ispModel - 8'd2, psr});
      else if (i == dp + 4)
        chk(memReq && !memWe && memAddr == TBASE + AW'(ec),
            "R6 vector read", memAddr, TBASE + AW'(ec));
      else begin
        chk(pcLoad && stall && pcNext == handlerOf(ec), "R6 handler pc", pcNext, handlerOf(ec));
        chk(psrLoad && psrNext == (psr & ~(16'h1 << IE_BIT)), "R7 entry psr",
            psrNext, psr & ~(16'h1 << IE_BIT));
        chk(ispOut == ispModel - 2, "R5 isp after push", ispOut, ispModel - 8'd2);
        chk(mem[ispModel - 1] == DW'(pc) && mem[ispModel - 2] == psr, "R5 stack content",
            mem[ispModel - 2], psr);
      end
    end
    @(negedge clk);
    chk(!stall && !pcLoad, "R4 stall release", {stall, pcLoad}, 0);
    stkPc[depth] = pc;
    stkPsr[depth] = psr;
    depth++;
    ispModel = ispModel - 2;
  endtask

  task automatic returnRun(input int dp);
    logic [AW-1:0] ePc;
    logic [DW-1:0] ePsr;
    depth--;
    ePc = stkPc[depth];
    ePsr = stkPsr[depth];
    @(negedge clk);
    retxReq = 1; pipeEmpty = 1;
    for (int i = 1; i <= dp + 4; i++) begin
      @(negedge clk);
      clearIn();
      pipeEmpty = (i > dp);
      if (i <= dp + 1)
        chk(stall && !memReq && !pcLoad, "R8 return drain", {stall, memReq}, 2'b10);
      else if (i == dp + 2)
        chk(memReq && !memWe && memAddr == ispModel, "R8 pop psr addr", memAddr, ispModel);
      else if (i == dp + 3)
        chk(memReq && !memWe && memAddr == ispModel + 1, "R8 pop pc addr", memAddr, ispModel + 8'd1);
      else begin
        chk(pcLoad && pcNext == ePc, "R8 restored pc", pcNext, ePc);
        chk(psrLoad && psrNext == ePsr, "R8 restored psr", psrNext, ePsr);
      end
    end
    @(negedge clk);
    ispModel = ispModel + 2;
    chk(ispOut == ispModel && !stall, "R8 isp after pop", ispOut, ispModel);
  endtask

  task automatic serialRun(input int dp);
    @(negedge clk);
    ctrlSerialize = 1; pipeEmpty = 1;
    for (int i = 1; i <= dp + 1; i++) begin
      @(negedge clk);
      clearIn();
      pipeEmpty = (i > dp);
      chk(stall && !memReq && !pcLoad && !psrLoad, "R9 serialize hold",
          {stall, memReq, pcLoad}, 3'b100);
    end
    @(negedge clk);
    chk(!stall && ispOut == ispModel, "R9 serialize release", stall, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 16'h0;
    for (int k = 0; k < 16; k++) mem[TBASE + k] = 16'h7700 | 16'(8'h40 + k * 5);
    ispModel = AW'(ISPR);
    repeat (3) @(negedge clk);
    chk(!stall && !memReq && !pcLoad && !psrLoad && !excTaken, "R1 reset outputs",
        {stall, memReq, pcLoad, psrLoad, excTaken}, 0);
    rstN = 1;
    @(negedge clk);
    chk(ispOut == AW'(ISPR) && !stall, "R1 isp reset", ispOut, ISPR);

    for (int ie = 0; ie < 2; ie++) begin
      for (int p = 0; p < 512; p++) begin
        entryRun(9'(p), ie[0], AW'(p * 3 + 1), p % 3, p[1]);
        if (expCode(9'(p), ie[0]) != 0) returnRun((p + 1) % 3);
      end
    end

    serialRun(0);
    serialRun(3);

    entryRun(9'h001, 1'b1, 8'h11, 1, 1'b0);
    entryRun(9'h080, 1'b0, 8'h22, 0, 1'b0);
    serialRun(2);
    returnRun(0);
    returnRun(2);
    chk(ispOut == AW'(ISPR), "R8 nested unwind", ispOut, ISPR);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule